// File: doc/BRIEF.md
# Palette Video Output Device Power-Up Sequencer

This block is a small bus master that brings a palette-based video output device into a known working state after power-up. Once reset is released it waits for a one-cycle start pulse. It then drives the device's 2-bit register select, its read/write line and its 8-bit data bus through a fixed list of writes, and it finishes by asserting a sticky done flag.

The fixed list has three parts. Five mode register writes come first. Bit 0 of these writes steps through 1, 0, 1 to clear the pixel pipelines. Bit 5 steps through 0, 1, 0 to align the load-clock timing. Next come four indirect register writes, each one a pointer write to the address register followed by a data write. The palette is then filled with a linear grey ramp: a single address write of zero, followed by 768 data writes that repeat each level once for red, once for green and once for blue. Every bus write takes three cycles, in the order setup, strobe, hold. While the sequence runs the block shows a busy indication, and any start pulse that arrives during that time has no effect.

The states are:
- `S_IDLE`: waits for start.
- `S_SETUP`: issues the 13 table writes.
- `S_PAL_ADDR`: issues the palette pointer write.
- `S_PAL_FILL`: issues the ramp writes.
- `S_DONE`: terminal state, held until reset.

The transitions are:
- `S_IDLE` to `S_SETUP` when start is seen.
- `S_SETUP` to `S_PAL_ADDR` at the hold phase of table entry 12.
- `S_PAL_ADDR` to `S_PAL_FILL` at the hold phase of the pointer write.
- `S_PAL_FILL` to `S_DONE` at the hold phase of the blue write for the top level.

Top module: `rdac_init_seq`

## Requirements
- R1: After reset, `done`, `busy` and `wr_stb` are 0, and they remain 0 until a start pulse is seen.
- R2: A start pulse seen in `S_IDLE` raises `busy` on the next cycle. `busy` then stays high until `done` rises.
- R3: The first five writes use select 2'b11 (mode register) with data 09h, 08h, 09h, 29h, 09h in that order. Across these writes bit 0 goes 1,0,1 and bit 5 goes 0,1,0.
- R4: Writes 6 to 13 are pairs. Each pair is a select 2'b00 (address) write of the pointer, then a select 2'b10 (control) write of the value. The pairs are 04h/FFh, 05h/00h, 06h/ECh and 07h/C0h, in that order.
- R5: Write 14 uses select 2'b00 with data 00h.
- R6: Writes 15 to 782 use select 2'b01 (palette). For every level n from 00h up to FFh in rising order, the value n is written three times in a row.
- R7: On each write, select and data keep the same value in the cycle before the strobe, the strobe cycle and the cycle after it. `wr_stb` is high for exactly one cycle per write.
- R8: `rnw` is 0 at every write.
- R9: `done` rises two cycles after the final strobe and stays high until reset. At that point `busy` is low and exactly 782 strobes have been issued.
- R10: A start pulse seen while `busy` is high, or while `done` is high, has no effect. The sequence is not restarted and no extra writes are issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start request |
| wr_stb | output | 1 | Write strobe, one cycle per write |
| sel | output | 2 | Register select: 00 address, 01 palette, 10 control, 11 mode |
| data | output | 8 | Write data bus |
| rnw | output | 1 | Read/write line, low for write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds the block with its default parameters: 256 ramp levels and 3 colour components. With these values the full 782-write run fits easily in the cycle budget, so the bench checks every write against the expected order. That includes the top-level blue write, the switch from table to pointer to ramp, and the two-cycle gap before `done`. A start pulse is injected in the middle of the run and another after completion, to show that neither restarts the sequence.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_ADDR = 2'b00;
    localparam logic [SEL_W-1:0] SEL_PAL  = 2'b01;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'b10;
    localparam logic [SEL_W-1:0] SEL_MODE = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_PAL_ADDR,
        S_PAL_FILL,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } bus_word_t;
endpackage

// File: rtl/rdi_setup_rom.sv
module rdi_setup_rom
    import rdi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output bus_word_t        word
);
    always_comb begin
        unique case (idx)
            IDX_W'(0):  word = '{sel: SEL_MODE, data: 8'h09};
            IDX_W'(1):  word = '{sel: SEL_MODE, data: 8'h08};
            IDX_W'(2):  word = '{sel: SEL_MODE, data: 8'h09};
            IDX_W'(3):  word = '{sel: SEL_MODE, data: 8'h29};
            IDX_W'(4):  word = '{sel: SEL_MODE, data: 8'h09};
            IDX_W'(5):  word = '{sel: SEL_ADDR, data: 8'h04};
            IDX_W'(6):  word = '{sel: SEL_CTRL, data: 8'hFF};
            IDX_W'(7):  word = '{sel: SEL_ADDR, data: 8'h05};
            IDX_W'(8):  word = '{sel: SEL_CTRL, data: 8'h00};
            IDX_W'(9):  word = '{sel: SEL_ADDR, data: 8'h06};
            IDX_W'(10): word = '{sel: SEL_CTRL, data: 8'hEC};
            IDX_W'(11): word = '{sel: SEL_ADDR, data: 8'h07};
            IDX_W'(12): word = '{sel: SEL_CTRL, data: 8'hC0};
            default:    word = '{sel: SEL_ADDR, data: 8'h00};
        endcase
    end
endmodule

// File: rtl/rdi_bus_phase.sv
module rdi_bus_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe,
    output logic last
);
    localparam int PHASES = 3;
    localparam int PH_W   = $clog2(PHASES);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q <= '0;
        end else if (ph_q == PH_W'(PHASES - 1)) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end

    assign strobe = run && (ph_q == PH_W'(1));
    assign last   = run && (ph_q == PH_W'(PHASES - 1));
endmodule

// File: rtl/rdi_pal_cnt.sv
module rdi_pal_cnt #(
    parameter int LEVELS = 256,
    parameter int COMPS  = 3,
    localparam int LW    = $clog2(LEVELS),
    localparam int CW    = $clog2(COMPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [LW-1:0] level,
    output logic          at_end
);
    logic [CW-1:0] comp_q;
    logic [LW-1:0] lvl_q;
    logic          comp_last;

    assign comp_last = (comp_q == CW'(COMPS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q <= '0;
            lvl_q  <= '0;
        end else if (step) begin
            if (comp_last) begin
                comp_q <= '0;
                lvl_q  <= lvl_q + LW'(1);
            end else begin
                comp_q <= comp_q + CW'(1);
            end
        end
    end

    assign level  = lvl_q;
    assign at_end = comp_last && (lvl_q == LW'(LEVELS - 1));
endmodule

// File: rtl/rdac_init_seq.sv
module rdac_init_seq
    import rdi_pkg::*;
#(
    parameter int LEVELS = 256,
    parameter int COMPS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             wr_stb,
    output logic [SEL_W-1:0] sel,
    output logic [DATA_W-1:0] data,
    output logic             rnw,
    output logic             busy,
    output logic             done
);
    localparam int SETUP_N = 13;
    localparam int IDX_W   = $clog2(SETUP_N);
    localparam int LW      = $clog2(LEVELS);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    bus_word_t        rom_word, out_word;
    logic             ph_strobe, ph_last, pal_end;
    logic [LW-1:0]    pal_level;

    rdi_setup_rom #(.IDX_W(IDX_W)) rom_i (
        .idx  (idx_q),
        .word (rom_word)
    );

    rdi_bus_phase phase_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .strobe (ph_strobe),
        .last   (ph_last)
    );

    rdi_pal_cnt #(.LEVELS(LEVELS), .COMPS(COMPS)) pal_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   ((state_q == S_PAL_FILL) && ph_last),
        .level  (pal_level),
        .at_end (pal_end)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_SETUP;
            S_SETUP:    if (ph_last && idx_q == IDX_W'(SETUP_N - 1)) state_d = S_PAL_ADDR;
            S_PAL_ADDR: if (ph_last) state_d = S_PAL_FILL;
            S_PAL_FILL: if (ph_last && pal_end) state_d = S_DONE;
            S_DONE:     state_d = S_DONE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_SETUP && ph_last && idx_q != IDX_W'(SETUP_N - 1)) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        out_word = '{sel: SEL_ADDR, data: '0};
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_SETUP:    begin out_word = rom_word; busy = 1'b1; end
            S_PAL_ADDR: begin out_word = '{sel: SEL_ADDR, data: '0}; busy = 1'b1; end
            S_PAL_FILL: begin out_word = '{sel: SEL_PAL, data: DATA_W'(pal_level)}; busy = 1'b1; end
            S_DONE:     done = 1'b1;
            default:    ;
        endcase
    end

    assign sel    = out_word.sel;
    assign data   = out_word.data;
    assign wr_stb = ph_strobe;
    assign rnw    = 1'b0;
endmodule

// File: rtl/rdi_init_seq_chk.sv
module rdi_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic [1:0] sel,
    input logic [7:0] data,
    input logic       busy,
    input logic       done
);
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r7_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($stable(sel) && $stable(data)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ($stable(sel) && $stable(data)));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_stb));

    a_r2_strobe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy);

    a_r2_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind rdac_init_seq rdi_init_seq_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .sel    (sel),
    .data   (data),
    .busy   (busy),
    .done   (done)
);

// File: tb/rdac_init_seq_tb_top.sv
module rdac_init_seq_tb_top;
    localparam int TOTAL = 782;
    localparam int N_TAB = 14;
    localparam logic [9:0] EXP_TAB [N_TAB] = '{
        {2'b11, 8'h09}, {2'b11, 8'h08}, {2'b11, 8'h09}, {2'b11, 8'h29}, {2'b11, 8'h09},
        {2'b00, 8'h04}, {2'b10, 8'hFF}, {2'b00, 8'h05}, {2'b10, 8'h00},
        {2'b00, 8'h06}, {2'b10, 8'hEC}, {2'b00, 8'h07}, {2'b10, 8'hC0},
        {2'b00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wr_stb, rnw, busy, done;
    logic [1:0] sel;
    logic [7:0] data;

    int tests = 0;
    int fails = 0;
    int n_wr = 0;
    int since_stb = 0;
    logic [9:0] log_w [1024];
    logic [9:0] prev_w;
    logic [9:0] strobe_w;
    logic       hold_chk = 1'b0;
    logic       done_seen = 1'b0;

    always #4 clk = ~clk;

    rdac_init_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_stb(wr_stb), .sel(sel),
        .data(data), .rnw(rnw), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            hold_chk  <= 1'b0;
            done_seen <= 1'b0;
            since_stb <= 0;
        end else begin
            if (hold_chk) begin
                check({sel, data} == strobe_w, "R7 hold", {sel, data}, strobe_w);
                check(!wr_stb, "R7 single strobe", wr_stb, 0);
            end
            hold_chk <= wr_stb;
            if (wr_stb) begin
                check({sel, data} == prev_w, "R7 setup", {sel, data}, prev_w);
                check(rnw == 1'b0, "R8 rnw", rnw, 0);
                if (n_wr < 1024) log_w[n_wr] = {sel, data};
                strobe_w = {sel, data};
                n_wr++;
                since_stb <= 0;
            end else begin
                since_stb <= since_stb + 1;
            end
            if (done && !done_seen) begin
                done_seen <= 1'b1;
                check(since_stb + 1 == 2, "R9 done timing", since_stb + 1, 2);
                check(!busy, "R9 busy low at done", busy, 0);
            end
        end
        prev_w = {sel, data};
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        int wd;
        bit wd_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset without start
        repeat (10) begin
            @(negedge clk);
            check(!done && !busy && !wr_stb, "R1 reset idle", {done, busy, wr_stb}, 0);
        end
        // R2: start raises busy on next cycle
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R2 busy after start", busy, 1);
        // R10: start during busy
        wait (n_wr == 20);
        pulse_start();
        // wait for done with watchdog
        wd = 0;
        wd_ok = 1'b1;
        while (!done) begin
            @(negedge clk);
            wd++;
            if (!busy && !done) check(1'b0, "R2 busy held", busy, 1);
            if (wd > 5000) begin
                wd_ok = 1'b0;
                break;
            end
        end
        check(wd_ok, "R9 watchdog", wd, 5000);
        // R3, R4, R5: walk the setup table
        for (int i = 0; i < N_TAB; i++) begin
            string r;
            r = (i < 5) ? "R3 mode write" : (i < 13) ? "R4 indirect write" : "R5 palette pointer";
            check(log_w[i] == EXP_TAB[i], r, log_w[i], EXP_TAB[i]);
        end
        // R6: ramp
        for (int i = N_TAB; i < TOTAL; i++) begin
            logic [9:0] e;
            e = {2'b01, 8'((i - N_TAB) / 3)};
            check(log_w[i] == e, "R6 ramp", log_w[i], e);
        end
        check(n_wr == TOTAL, "R9 R10 write count", n_wr, TOTAL);
        // R10: start after done
        pulse_start();
        repeat (30) @(negedge clk);
        check(n_wr == TOTAL, "R10 start after done", n_wr, TOTAL);
        check(done && !busy, "R9 done sticky", {done, busy}, 2);
        // R1: reset clears done
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && !wr_stb, "R1 reset after done", {done, busy, wr_stb}, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule